// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Byte Port

This block is a full-duplex byte-wide serial port that can either generate the serial clock itself or follow a clock from a remote device. Each transfer moves one byte out and one byte in at the same time through a single internal shift register. The host cannot reach that shift register. Writing the buffer port preloads the shift register and, in clock-generator mode, starts the transfer. Reading the buffer port returns the most recently captured byte.

A completed byte lands in a receive holding register. The block then raises a buffer-full flag and an interrupt-request flag. Because of this second register, the next byte can shift while the host has not yet collected the previous one. Host writes made mid-transfer are dropped and recorded in a sticky collision flag. A byte that completes while the holding register is still unread is discarded, and a sticky overflow flag records the loss. A 4-bit mode field selects the clock source and rate, or one of two follower modes (with or without the chip-select input). A polarity bit selects the idle level of the serial clock.

Top module: `spi_dualbuf_port`

## Requirements
- R1: In clock-generator modes (mode 0 to 3) a host write starts a transfer of exactly 8 bits. `sdo` presents the written byte most-significant bit first.
- R2: At the end of the 8th bit, the byte assembled from `sdi` (first bit in bit 7) appears on `rd_data`, and `buf_full` and `irq` both go to 1.
- R3: A one-cycle `rd_en` pulse clears `buf_full`. `irq` stays 1 until a `clr_irq` pulse.
- R4: A host write while a transfer is in progress is ignored and sets `wcol`. The transfer continues with the earlier byte, and `wcol` stays 1 until a `clr_wcol` pulse.
- R5: If a byte completes while `buf_full` is 1, `rd_data` keeps the old byte and `ovf` goes to 1. `ovf` stays 1 until a `clr_ovf` pulse.
- R6: Mode 0, 1 and 2 give a serial clock period of 4, 16 and 64 `clk` cycles.
- R7: In mode 3 each `tmr_pulse` is one half-period of the serial clock, so one clock period spans two pulses.
- R8: `cfg_cpol`=0 gives an idle-low clock. `cfg_cpol`=1 gives an idle-high clock. Input data is sampled on the edge leaving the idle level, and output data changes on the edge returning to it.
- R9: In mode 5 (follower, select ignored) edges on `sck_i` shift the preloaded byte out on `sdo` and capture a byte from `sdi`, with the same flag behaviour as R2.
- R10: In mode 4 (follower with select) a high `ss_n` drives `sdo_oe` low and resets the bit count. A partially received byte is discarded, without setting `buf_full`.
- R11: With `cfg_enable`=0, or with a mode code of 6 to 15, the port is idle. `sck_o` holds the `cfg_cpol` level, and writes are ignored without setting `wcol`.
- R12: After reset `rd_data` is 0 and `buf_full`, `irq`, `wcol` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global port enable |
| cfg_mode | input | 4 | Mode: 0..2 generator at /4,/16,/64; 3 generator from timer; 4 follower with select; 5 follower without select |
| cfg_cpol | input | 1 | Serial clock idle level |
| wr_en | input | 1 | Host write strobe for the buffer port |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe, clears buffer-full |
| rd_data | output | 8 | Last received byte |
| clr_irq | input | 1 | Clears the interrupt-request flag |
| clr_wcol | input | 1 | Clears the collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| buf_full | output | 1 | Receive holding register holds an unread byte |
| irq | output | 1 | Transfer-complete interrupt request |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| tmr_pulse | input | 1 | External timer pulse for mode 3 |
| sck_i | input | 1 | Serial clock input in follower modes |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low follower select |

## Verification
The hardest situation to reach is a select release in the middle of a byte in follower mode. The bench has to stop clocking after a few bits, raise `ss_n` long enough to pass the input synchronizer, and confirm that no byte was delivered. It then proves the counter restarted by sending a full fresh byte and checking that it arrives intact. Collision and overflow are reached by a second write one cycle after the first, and by a second complete transfer with no read in between.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef logic [3:0] mode_t;

   localparam mode_t MODE_GEN_A   = 4'd0;
   localparam mode_t MODE_GEN_B   = 4'd1;
   localparam mode_t MODE_GEN_C   = 4'd2;
   localparam mode_t MODE_GEN_TMR = 4'd3;
   localparam mode_t MODE_FOL_SEL = 4'd4;
   localparam mode_t MODE_FOL_ANY = 4'd5;

   typedef struct packed {
      logic       gen;      // port drives the serial clock
      logic       fol;      // port follows an external clock
      logic       sel_used; // follower honours ss_n
      logic [1:0] rate;     // clock source select in generator modes
   } mode_dec_t;

   function automatic mode_dec_t decode_mode(input mode_t m);
      mode_dec_t d;
      d.gen      = (m <= MODE_GEN_TMR);
      d.fol      = (m == MODE_FOL_SEL) || (m == MODE_FOL_ANY);
      d.sel_used = (m == MODE_FOL_SEL);
      d.rate     = m[1:0];
      return d;
   endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("spi_in_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {STAGES{RST_VAL}};
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
   parameter int DIV_A = 4,
   parameter int DIV_B = 16,
   parameter int DIV_C = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   input  logic       tmr_pulse,
   output logic       tick
);

   localparam int HALF_A = DIV_A / 2;
   localparam int HALF_B = DIV_B / 2;
   localparam int HALF_C = DIV_C / 2;
   localparam int CNT_W  = $clog2(HALF_C) + 1;
   localparam logic [CNT_W-1:0] LIM_A = CNT_W'(HALF_A - 1);
   localparam logic [CNT_W-1:0] LIM_B = CNT_W'(HALF_B - 1);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(HALF_C - 1);

   if (DIV_A < 2 || (DIV_A % 2) != 0 || (DIV_B % 2) != 0 || (DIV_C % 2) != 0)
   begin : g_bad_div
      $error("spi_rate_gen: dividers must be even and at least 2");
   end
   if (!(DIV_A < DIV_B && DIV_B < DIV_C)) begin : g_bad_order
      $error("spi_rate_gen: dividers must increase A < B < C");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             use_tmr;

   assign use_tmr = (rate == 2'd3);

   always_comb begin
      case (rate)
         2'd0:    lim = LIM_A;
         2'd1:    lim = LIM_B;
         default: lim = LIM_C;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || use_tmr)     cnt <= '0;
      else if (cnt == lim)          cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   assign tick = run && (use_tmr ? tmr_pulse : (cnt == lim));

   // R6: the divider counter never passes the selected limit
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !use_tmr && $stable(rate) && cnt <= lim) |=> (cnt <= lim));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         is_gen,
   input  logic         sel_used,
   input  logic         cpol,
   input  logic         tick,
   input  logic         sck_s,
   input  logic         sdi_raw,
   input  logic         sdi_s,
   input  logic         ss_s,
   input  logic         load,
   input  logic [W-1:0] load_data,
   output logic         sdo,
   output logic         sck_q,
   output logic         busy,
   output logic         active,
   output logic         done,
   output logic [W-1:0] done_data
);

   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_width
      $error("spi_shift_core: W must be at least 2");
   end

   logic [W-1:0]  shreg;
   logic [CW-1:0] bitcnt;
   logic          half;
   logic          rx_bit;
   logic          sck_prev;
   logic          fol_run;
   logic          deselect;
   logic          sck_edge;
   logic          lead;
   logic          trail;
   logic          last;
   logic          sample;

   assign deselect = !is_gen && sel_used && ss_s;
   assign fol_run  = en && !is_gen && !deselect;
   assign sck_edge = (sck_s != sck_prev);
   assign sample   = is_gen ? sdi_raw : sdi_s;
   assign last     = (bitcnt == LAST);

   always_comb begin
      if (is_gen) begin
         lead  = en && active && tick && (sck_q == cpol);
         trail = en && active && tick && (sck_q != cpol);
      end else begin
         lead  = fol_run && sck_edge && (sck_s != cpol);
         trail = fol_run && sck_edge && (sck_s == cpol) && half;
      end
   end

   assign done      = trail && last;
   assign done_data = {shreg[W-2:0], rx_bit};
   assign busy      = active || half || (bitcnt != '0);
   assign sdo       = shreg[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         bitcnt   <= '0;
         half     <= 1'b0;
         rx_bit   <= 1'b0;
         sck_prev <= 1'b0;
         sck_q    <= 1'b0;
         active   <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         if (!en) begin
            active <= 1'b0;
            half   <= 1'b0;
            bitcnt <= '0;
            sck_q  <= cpol;
         end else begin
            if (deselect) begin
               half   <= 1'b0;
               bitcnt <= '0;
            end
            if (!active) sck_q <= cpol;
            if (load) begin
               shreg <= load_data;
               if (is_gen) active <= 1'b1;
            end
            if (lead) begin
               rx_bit <= sample;
               half   <= 1'b1;
               if (is_gen) sck_q <= ~cpol;
            end
            if (trail) begin
               shreg  <= done_data;
               half   <= 1'b0;
               bitcnt <= last ? '0 : bitcnt + 1'b1;
               if (is_gen) begin
                  sck_q <= cpol;
                  if (last) active <= 1'b0;
               end
            end
         end
      end
   end

   // R11: a disabled port keeps its bit counter cleared and stops
   assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (bitcnt == '0 && !active));

   // R10: a released select resets the count and the half-bit state
   assert_deselect_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && deselect) |=> (bitcnt == '0 && !half));

   // R1: a generator transfer ends after its last bit
   assert_gen_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_gen) |=> !active);

   // R4: new data is only loaded when no transfer is running
   assert_load_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/spi_host_buf.sv
module spi_host_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         done,
   input  logic [W-1:0] done_data,
   input  logic         rd_en,
   input  logic         wcol_set,
   input  logic         clr_irq,
   input  logic         clr_wcol,
   input  logic         clr_ovf,
   output logic [W-1:0] rx_buf,
   output logic         buf_full,
   output logic         irq,
   output logic         wcol,
   output logic         ovf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf   <= '0;
         buf_full <= 1'b0;
         irq      <= 1'b0;
         wcol     <= 1'b0;
         ovf      <= 1'b0;
      end else begin
         if (done) begin
            irq <= 1'b1;
            if (buf_full) begin
               ovf <= 1'b1;
            end else begin
               rx_buf   <= done_data;
               buf_full <= 1'b1;
            end
         end else begin
            if (rd_en)   buf_full <= 1'b0;
            if (clr_irq) irq      <= 1'b0;
            if (clr_ovf) ovf      <= 1'b0;
         end
         if (wcol_set)      wcol <= 1'b1;
         else if (clr_wcol) wcol <= 1'b0;
      end
   end

   // R2: a byte arriving to an empty holding register fills it and requests service
   assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !buf_full) |=> (buf_full && irq && rx_buf == $past(done_data)));

   // R5: a byte arriving to a full holding register leaves it untouched
   assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && buf_full) |=> (ovf && $stable(rx_buf)));

   // R3: a read with no completing byte empties the holding register
   assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !done) |=> !buf_full);

   // R4: the collision flag holds until cleared
   assert_wcol_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol && !clr_wcol) |=> wcol);

endmodule

// File: rtl/spi_dualbuf_port.sv
module spi_dualbuf_port
   import spi_port_pkg::*;
#(
   parameter int W           = 8,
   parameter int DIV_A       = 4,
   parameter int DIV_B       = 16,
   parameter int DIV_C       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_enable,
   input  logic [3:0]   cfg_mode,
   input  logic         cfg_cpol,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   input  logic         clr_irq,
   input  logic         clr_wcol,
   input  logic         clr_ovf,
   output logic         buf_full,
   output logic         irq,
   output logic         wcol,
   output logic         ovf,
   input  logic         tmr_pulse,
   input  logic         sck_i,
   output logic         sck_o,
   output logic         sck_oe,
   input  logic         sdi,
   output logic         sdo,
   output logic         sdo_oe,
   input  logic         ss_n
);

   localparam logic [2:0] SYNC_RST = 3'b001; // {sck, sdi, ss_n}

   mode_dec_t   dec;
   logic        en;
   logic [2:0]  sync_q;
   logic        sck_s, sdi_s, ss_s;
   logic        tick;
   logic        sck_q;
   logic        busy;
   logic        active;
   logic        done;
   logic [W-1:0] done_data;
   logic        load;
   logic        wcol_set;

   assign dec = decode_mode(cfg_mode);
   assign en  = cfg_enable && (dec.gen || dec.fol);

   spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_i, sdi, ss_n}),
      .q     (sync_q)
   );
   assign {sck_s, sdi_s, ss_s} = sync_q;

   spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (active && en && dec.gen),
      .rate      (dec.rate),
      .tmr_pulse (tmr_pulse),
      .tick      (tick)
   );

   assign load     = wr_en && en && !busy;
   assign wcol_set = wr_en && en && busy;

   spi_shift_core #(.W(W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .is_gen    (dec.gen),
      .sel_used  (dec.sel_used),
      .cpol      (cfg_cpol),
      .tick      (tick),
      .sck_s     (sck_s),
      .sdi_raw   (sdi),
      .sdi_s     (sdi_s),
      .ss_s      (ss_s),
      .load      (load),
      .load_data (wr_data),
      .sdo       (sdo),
      .sck_q     (sck_q),
      .busy      (busy),
      .active    (active),
      .done      (done),
      .done_data (done_data)
   );

   spi_host_buf #(.W(W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .done_data (done_data),
      .rd_en     (rd_en),
      .wcol_set  (wcol_set),
      .clr_irq   (clr_irq),
      .clr_wcol  (clr_wcol),
      .clr_ovf   (clr_ovf),
      .rx_buf    (rd_data),
      .buf_full  (buf_full),
      .irq       (irq),
      .wcol      (wcol),
      .ovf       (ovf)
   );

   assign sck_o  = (en && dec.gen) ? sck_q : cfg_cpol;
   assign sck_oe = en && dec.gen;
   assign sdo_oe = en && (dec.gen || !dec.sel_used || !ss_s);

   // R11: with the port idle a write never raises a collision
   assert_off_no_wcol_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wcol && !clr_wcol) |=> !wcol);

   // R8: the clock output rests at the polarity level when no transfer runs
   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $stable(cfg_cpol) && $past(!active)) |-> (sck_o == cfg_cpol));

endmodule

// File: tb/sim_spi_dualbuf_port.sv
module sim_spi_dualbuf_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0;
   logic [3:0] cfg_mode = 4'd0;
   logic       cfg_cpol = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       clr_irq = 1'b0, clr_wcol = 1'b0, clr_ovf = 1'b0;
   logic       buf_full, irq, wcol, ovf;
   logic       tmr_pulse = 1'b0;
   logic       sck_i = 1'b0;
   logic       sck_o, sck_oe;
   logic       sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic       ss_n = 1'b1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit tmr_on = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) tmr_pulse = tmr_on && (cyc % 5 == 0);

   spi_dualbuf_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
      .cfg_cpol(cfg_cpol), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .clr_irq(clr_irq), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf),
      .buf_full(buf_full), .irq(irq), .wcol(wcol), .ovf(ovf), .tmr_pulse(tmr_pulse),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
      .sdo_oe(sdo_oe), .ss_n(ss_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic setup(input bit en, input logic [3:0] m, input bit pol);
      @(negedge clk); cfg_enable = en; cfg_mode = m; cfg_cpol = pol;
      repeat (4) @(negedge clk);
   endtask

   // Generator-mode transfer with a remote device model on sdi/sdo.
   task automatic gen_xfer(input logic [7:0] tx, input logic [7:0] remote,
                           input logic [7:0] exp_rx, input int exp_period,
                           input bit collide, input string req);
      logic [7:0] got;
      int t0, t1;
      logic act_lvl;
      act_lvl = ~cfg_cpol;
      t0 = 0; t1 = 0; got = 8'h00;
      sdi = remote[7];
      host_write(tx);
      if (collide) begin
         wr_en = 1'b1; wr_data = ~tx;
         @(negedge clk); wr_en = 1'b0;
      end
      for (int i = 7; i >= 0; i--) begin
         while (sck_o != act_lvl) @(negedge clk);
         if (i == 7) t0 = cyc;
         if (i == 6) t1 = cyc;
         got[i] = sdo;
         while (sck_o != cfg_cpol) @(negedge clk);
         if (i > 0) sdi = remote[i-1];
      end
      @(negedge clk);
      chk(got == tx, "R1", "bits sent on sdo", got, tx);
      chk(rd_data == exp_rx, req, "received byte", rd_data, exp_rx);
      chk(buf_full == 1'b1, "R2", "buf_full after transfer", buf_full, 1);
      chk(irq == 1'b1, "R2", "irq after transfer", irq, 1);
      if (exp_period > 0)
         chk((t1 - t0) == exp_period, req, "serial clock period", t1 - t0, exp_period);
   endtask

   // Follower-mode bit sequence driven on sck_i (idle low).
   task automatic fol_bits(input logic [7:0] tx, input logic [7:0] remote,
                           input int nbits, input string req);
      for (int i = 7; i > 7 - nbits; i--) begin
         sdi = remote[i];
         repeat (8) @(negedge clk);
         chk(sdo == tx[i], req, "follower sdo bit", sdo, tx[i]);
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
         sck_i = 1'b0;
         repeat (8) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(rd_data == 8'h00, "R12", "rd_data after reset", rd_data, 0);
      chk({buf_full, irq, wcol, ovf} == 4'b0000, "R12", "flags after reset",
          {buf_full, irq, wcol, ovf}, 0);
   endtask

   task automatic t_gen_basic();
      setup(1'b1, 4'd0, 1'b0);
      gen_xfer(8'hA5, 8'h3C, 8'h3C, 4, 1'b0, "R6");
      pulse(rd_en);
      chk(buf_full == 1'b0, "R3", "buf_full after read", buf_full, 0);
      chk(irq == 1'b1, "R3", "irq survives read", irq, 1);
      pulse(clr_irq);
      chk(irq == 1'b0, "R3", "irq after clear", irq, 0);
   endtask

   task automatic t_rates();
      setup(1'b1, 4'd1, 1'b0);
      gen_xfer(8'h5A, 8'hC3, 8'hC3, 16, 1'b0, "R6");
      pulse(rd_en);
      setup(1'b1, 4'd2, 1'b0);
      gen_xfer(8'h0F, 8'hF0, 8'hF0, 64, 1'b0, "R6");
      pulse(rd_en);
   endtask

   task automatic t_timer();
      setup(1'b1, 4'd3, 1'b0);
      tmr_on = 1'b1;
      gen_xfer(8'h96, 8'h69, 8'h69, 10, 1'b0, "R7");
      tmr_on = 1'b0;
      pulse(rd_en);
   endtask

   task automatic t_polarity();
      setup(1'b1, 4'd0, 1'b1);
      chk(sck_o == 1'b1, "R8", "idle level with polarity 1", sck_o, 1);
      gen_xfer(8'hE1, 8'h1E, 8'h1E, 4, 1'b0, "R8");
      pulse(rd_en);
      setup(1'b1, 4'd0, 1'b0);
      chk(sck_o == 1'b0, "R8", "idle level with polarity 0", sck_o, 0);
   endtask

   task automatic t_collision();
      setup(1'b1, 4'd0, 1'b0);
      gen_xfer(8'h81, 8'h42, 8'h42, 0, 1'b1, "R4");
      chk(wcol == 1'b1, "R4", "wcol after mid-transfer write", wcol, 1);
      repeat (5) @(negedge clk);
      chk(wcol == 1'b1, "R4", "wcol still held", wcol, 1);
      pulse(clr_wcol);
      chk(wcol == 1'b0, "R4", "wcol after clear", wcol, 0);
      pulse(rd_en);
   endtask

   task automatic t_overflow();
      setup(1'b1, 4'd0, 1'b0);
      gen_xfer(8'h11, 8'hAA, 8'hAA, 0, 1'b0, "R2");
      gen_xfer(8'h22, 8'h55, 8'hAA, 0, 1'b0, "R5");
      chk(ovf == 1'b1, "R5", "ovf after unread byte", ovf, 1);
      pulse(clr_ovf);
      chk(ovf == 1'b0, "R5", "ovf after clear", ovf, 0);
      pulse(rd_en);
      pulse(clr_irq);
   endtask

   task automatic t_follower_free();
      setup(1'b1, 4'd5, 1'b0);
      ss_n = 1'b1;
      host_write(8'hB4);
      chk(sdo_oe == 1'b1, "R9", "sdo_oe without select", sdo_oe, 1);
      fol_bits(8'hB4, 8'h2D, 8, "R9");
      chk(buf_full == 1'b1, "R9", "buf_full after follower byte", buf_full, 1);
      chk(rd_data == 8'h2D, "R9", "follower received byte", rd_data, 8'h2D);
      pulse(rd_en);
   endtask

   task automatic t_follower_sel();
      setup(1'b1, 4'd4, 1'b0);
      ss_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sdo_oe == 1'b0, "R10", "sdo_oe while deselected", sdo_oe, 0);
      ss_n = 1'b0;
      repeat (4) @(negedge clk);
      host_write(8'hC7);
      fol_bits(8'hC7, 8'hFF, 3, "R10");
      ss_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(sdo_oe == 1'b0, "R10", "sdo_oe after release", sdo_oe, 0);
      chk(buf_full == 1'b0, "R10", "partial byte discarded", buf_full, 0);
      ss_n = 1'b0;
      repeat (4) @(negedge clk);
      host_write(8'h3A);
      fol_bits(8'h3A, 8'h94, 8, "R10");
      chk(rd_data == 8'h94, "R10", "fresh byte after restart", rd_data, 8'h94);
      chk(wcol == 1'b0, "R10", "restart write accepted", wcol, 0);
      pulse(rd_en);
      ss_n = 1'b1;
   endtask

   task automatic t_disabled();
      pulse(clr_irq);
      setup(1'b0, 4'd0, 1'b1);
      host_write(8'h77);
      repeat (20) @(negedge clk);
      chk(sck_o == 1'b1, "R11", "clock level while disabled", sck_o, 1);
      chk(wcol == 1'b0 && buf_full == 1'b0 && irq == 1'b0, "R11",
          "no activity while disabled", {wcol, buf_full, irq}, 0);
      setup(1'b1, 4'd9, 1'b0);
      host_write(8'h66);
      repeat (20) @(negedge clk);
      chk(sck_o == 1'b0 && sck_oe == 1'b0, "R11", "reserved mode idle",
          {sck_oe, sck_o}, 0);
      chk(wcol == 1'b0 && buf_full == 1'b0, "R11", "reserved mode ignores write",
          {wcol, buf_full}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gen_basic();
      t_rates();
      t_timer();
      t_polarity();
      t_collision();
      t_overflow();
      t_follower_free();
      t_follower_sel();
      t_disabled();
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

endmodule